// File: doc/BRIEF.md
# Row-Latched SRAM Read Controller

This controller sits in front of a 4 KB word-addressed memory array (four 1 KB banks, 2048 sixteen-bit words) and cuts read energy by keeping the last activated array row in a 128-bit latch. A full read activates one row, which holds eight 16-bit words, and captures the whole row. Any later read whose address falls in that same row is answered from the latch through a 128-to-16 word selector, and the array's decoders and word-line drivers stay quiet. No command selects the cheap path: the controller compares the upper address bits with the tag of the latched row and decides on its own.

Requests (reads and writes) arrive on a valid/ready channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so it drops while a row fill, an array write or an unconsumed response is in flight. Read data leaves on a valid/ready response channel. Once `rsp_valid` rises, it stays high with `rsp_data` unchanged until a clock edge sees `rsp_ready` high. Writes produce no response. They go to the array, and when they target the latched row they also patch the latched copy. Two saturating counters report how many reads took each path.

Top module: `row_latch_rd_ctrl`

## Requirements
- R1: After reset the latch holds no valid row, `rsp_valid`, `row_act` and `arr_wr` are low, `req_ready` is high and both counters are zero. A first read of address 0 is therefore a full read.
- R2: A read whose address bits [10:3] do not match a valid latched row asserts `row_act` from the cycle after acceptance, with `row_addr` = address[10:3]. The strobe holds until a cycle with `row_ready` high. `rsp_valid` rises in the next cycle.
- R3: A read whose address bits [10:3] match the valid latched tag raises `rsp_valid` in the cycle after acceptance. `row_act` stays low for the whole transaction.
- R4: The word returned is selected by address bits [2:0]: word w is bits [16w+15:16w] of the row. This holds both for hits and for the row delivered on `row_data`.
- R5: After one full read of a row, reads of the other seven words of that row are all served without a row activation.
- R6: An accepted write drives `arr_wr` high from the next cycle, with `arr_waddr` and `arr_wdata` equal to the request, until a cycle with `row_ready` high. No response is produced.
- R7: A write into the latched row updates the latched word, so a later hit returns the new value. A write into any other row leaves the latch unchanged.
- R8: While `rsp_valid` is high and `rsp_ready` low, `rsp_valid` and `rsp_data` hold steady and `req_ready` is low.
- R9: `cnt_full` counts completed full reads and `cnt_ler` counts latch-served reads. Each saturates at all ones and changes on no other event.
- R10: On a fill, the response word is taken from the incoming row in the same cycle that the latch loads, never from the prior latch contents. The previously latched row stops hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address: [10:9] bank, [8:3] row, [2:0] word |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer accepts read data |
| rsp_data | output | 16 | Read data |
| row_act | output | 1 | Array row activation strobe |
| row_addr | output | 8 | Bank and row to activate |
| row_ready | input | 1 | Array finished the current activation or write |
| row_data | input | 128 | Full row from the array |
| arr_wr | output | 1 | Array word write strobe |
| arr_waddr | output | 11 | Array write word address |
| arr_wdata | output | 16 | Array write data |
| cnt_full | output | 8 | Saturating count of full reads |
| cnt_ler | output | 8 | Saturating count of latch-served reads |

## Verification
The fill path has two operations landing on the same clock edge: the latch loads the incoming row, and the response register picks its word. If the word were taken from the old latch, the returned value would come from the wrong row. The bench provokes this with a miss that follows a hit in a different row, where both rows hold different values at the same word index. It then judges the response against its own memory model at the requested address, and checks that a return to the old row is a miss again. A write patch to the latched row is also followed at once by a read hit to the same word, which must return the new value.

// File: rtl/row_latch_pkg.sv
package row_latch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } rlc_state_e;
endpackage

// File: rtl/rlc_word_sel.sv
module rlc_word_sel #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  localparam int SEL_W = $clog2(WORDS),
  localparam int ROW_W = WORD_W * WORDS
) (
  input  logic [ROW_W-1:0]  row,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] lane [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_lane
    assign lane[i] = row[i*WORD_W +: WORD_W];
  end

  assign word = lane[sel];
endmodule

// File: rtl/rlc_tag_match.sv
module rlc_tag_match #(
  parameter int TAG_W = 8
) (
  input  logic             held_valid,
  input  logic [TAG_W-1:0] held_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             match
);
  assign match = held_valid && (held_tag == probe_tag);
endmodule

// File: rtl/rlc_row_latch.sv
module rlc_row_latch #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 8,
  localparam int SEL_W = $clog2(WORDS),
  localparam int ROW_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ROW_W-1:0]  load_row,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic              patch,
  input  logic [SEL_W-1:0]  patch_sel,
  input  logic [WORD_W-1:0] patch_data,
  output logic              held_valid,
  output logic [TAG_W-1:0]  held_tag,
  output logic [ROW_W-1:0]  held_row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_tag   <= '0;
    end else if (load) begin
      held_valid <= 1'b1;
      held_tag   <= load_tag;
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (load) begin
        q <= load_row[i*WORD_W +: WORD_W];
      end else if (patch && (patch_sel == SEL_W'(i))) begin
        q <= patch_data;
      end
    end
    assign held_row[i*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/rlc_sat_counter.sv
module rlc_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (bump && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/row_latch_rd_ctrl.sv
module row_latch_rd_ctrl
  import row_latch_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  parameter int CNT_W  = 8,
  localparam int SEL_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - SEL_W,
  localparam int ROW_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              row_act,
  output logic [TAG_W-1:0]  row_addr,
  input  logic              row_ready,
  input  logic [ROW_W-1:0]  row_data,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [WORD_W-1:0] arr_wdata,
  output logic [CNT_W-1:0]  cnt_full,
  output logic [CNT_W-1:0]  cnt_ler
);
  rlc_state_e state_q;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_wdata;

  logic              lat_valid;
  logic [TAG_W-1:0]  lat_tag;
  logic [ROW_W-1:0]  lat_row;
  logic [WORD_W-1:0] lat_word;
  logic [WORD_W-1:0] fill_word;
  logic              req_hit;
  logic              pend_hit;

  logic [TAG_W-1:0]  req_tag;
  logic [SEL_W-1:0]  req_sel;
  logic [TAG_W-1:0]  pend_tag;
  logic [SEL_W-1:0]  pend_sel;

  assign req_tag  = req_addr[ADDR_W-1:SEL_W];
  assign req_sel  = req_addr[SEL_W-1:0];
  assign pend_tag = pend_addr[ADDR_W-1:SEL_W];
  assign pend_sel = pend_addr[SEL_W-1:0];

  logic take;
  logic take_rd_hit;
  logic fill_done;
  logic write_done;

  assign req_ready   = (state_q == ST_IDLE);
  assign take        = req_valid && req_ready;
  assign take_rd_hit = take && !req_we && req_hit;
  assign fill_done   = (state_q == ST_FILL) && row_ready;
  assign write_done  = (state_q == ST_WRITE) && row_ready;

  rlc_tag_match #(.TAG_W(TAG_W)) u_req_match (
    .held_valid (lat_valid),
    .held_tag   (lat_tag),
    .probe_tag  (req_tag),
    .match      (req_hit)
  );

  rlc_tag_match #(.TAG_W(TAG_W)) u_wr_match (
    .held_valid (lat_valid),
    .held_tag   (lat_tag),
    .probe_tag  (pend_tag),
    .match      (pend_hit)
  );

  rlc_row_latch #(.WORD_W(WORD_W), .WORDS(WORDS), .TAG_W(TAG_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (fill_done),
    .load_row   (row_data),
    .load_tag   (pend_tag),
    .patch      (write_done && pend_hit),
    .patch_sel  (pend_sel),
    .patch_data (pend_wdata),
    .held_valid (lat_valid),
    .held_tag   (lat_tag),
    .held_row   (lat_row)
  );

  rlc_word_sel #(.WORD_W(WORD_W), .WORDS(WORDS)) u_hit_sel (
    .row  (lat_row),
    .sel  (req_sel),
    .word (lat_word)
  );

  rlc_word_sel #(.WORD_W(WORD_W), .WORDS(WORDS)) u_fill_sel (
    .row  (row_data),
    .sel  (pend_sel),
    .word (fill_word)
  );

  rlc_sat_counter #(.CNT_W(CNT_W)) u_cnt_full (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (fill_done),
    .count (cnt_full)
  );

  rlc_sat_counter #(.CNT_W(CNT_W)) u_cnt_ler (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (take_rd_hit),
    .count (cnt_ler)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_addr  <= '0;
      pend_wdata <= '0;
      rsp_data   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            pend_addr <= req_addr;
            if (req_we) begin
              pend_wdata <= req_wdata;
              state_q    <= ST_WRITE;
            end else if (req_hit) begin
              rsp_data <= lat_word;
              state_q  <= ST_RESP;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (row_ready) begin
            rsp_data <= fill_word;
            state_q  <= ST_RESP;
          end
        end
        ST_WRITE: begin
          if (row_ready) begin
            state_q <= ST_IDLE;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign row_act   = (state_q == ST_FILL);
  assign row_addr  = pend_tag;
  assign arr_wr    = (state_q == ST_WRITE);
  assign arr_waddr = pend_addr;
  assign arr_wdata = pend_wdata;
endmodule

// File: rtl/row_latch_rd_ctrl_chk.sv
module row_latch_rd_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  parameter int CNT_W  = 8,
  localparam int SEL_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - SEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_data,
  input logic              row_act,
  input logic [TAG_W-1:0]  row_addr,
  input logic              row_ready,
  input logic              arr_wr,
  input logic [CNT_W-1:0]  cnt_full,
  input logic [CNT_W-1:0]  cnt_ler,
  input logic              lat_valid,
  input logic [TAG_W-1:0]  lat_tag
);
  logic rd_take;
  logic tag_eq;
  assign rd_take = req_valid && req_ready && !req_we;
  assign tag_eq  = lat_valid && (lat_tag == req_addr[ADDR_W-1:SEL_W]);

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && tag_eq) |=> (rsp_valid && !row_act)) else $error("hit latency"); // R3

  AST_MISS_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !tag_eq) |=> (row_act && row_addr == $past(req_addr[ADDR_W-1:SEL_W]))) else $error("miss act"); // R2

  AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (row_act && !row_ready) |=> (row_act && $stable(row_addr))) else $error("act hold"); // R2

  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (row_act && row_ready) |=> rsp_valid) else $error("fill rsp"); // R2

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && row_ready) |=> !rsp_valid) else $error("write rsp"); // R6

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))) else $error("rsp stall"); // R8

  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready) else $error("busy ready"); // R8

  AST_FULL_CNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_act && row_ready) |=> $stable(cnt_full)) else $error("full cnt"); // R9

  AST_LER_CNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_take && tag_eq) |=> $stable(cnt_ler)) else $error("ler cnt"); // R9
endmodule

bind row_latch_rd_ctrl row_latch_rd_ctrl_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .row_act(row_act),
  .row_addr(row_addr), .row_ready(row_ready), .arr_wr(arr_wr),
  .cnt_full(cnt_full), .cnt_ler(cnt_ler), .lat_valid(lat_valid),
  .lat_tag(lat_tag)
);

// File: tb/row_latch_rd_ctrl_test.sv
module row_latch_rd_ctrl_test;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_we = 1'b0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic row_act;
  logic [7:0] row_addr;
  logic row_ready = 1'b0;
  logic [127:0] row_data = '0;
  logic arr_wr;
  logic [10:0] arr_waddr;
  logic [15:0] arr_wdata;
  logic [7:0] cnt_full;
  logic [7:0] cnt_ler;

  always #2.5 clk = ~clk;

  row_latch_rd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .row_act(row_act), .row_addr(row_addr), .row_ready(row_ready),
    .row_data(row_data), .arr_wr(arr_wr), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .cnt_full(cnt_full), .cnt_ler(cnt_ler)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [15:0] arr_mem [2048];
  logic [15:0] ref_mem [2048];

  function automatic logic [15:0] seed_val(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // array model: answers after LAT wait cycles
  int wcnt = 0;
  always @(negedge clk) begin
    if (row_act || arr_wr) begin
      if (wcnt == LAT) begin
        row_ready <= 1'b1;
        if (arr_wr) arr_mem[arr_waddr] = arr_wdata;
      end else begin
        row_ready <= 1'b0;
        wcnt = wcnt + 1;
      end
    end else begin
      wcnt = 0;
      row_ready <= 1'b0;
    end
    for (int i = 0; i < 8; i++) row_data[i*16 +: 16] <= arr_mem[{row_addr, i[2:0]}];
  end

  task automatic do_read(input logic [10:0] a, output logic [15:0] d,
                         output bit act_seen, output int lat, output bit row_ok);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; act_seen = 1'b0; row_ok = 1'b1;
    while (!rsp_valid && lat < 50) begin
      if (row_act) begin
        act_seen = 1'b1;
        if (row_addr != a[10:3]) row_ok = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    d = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic do_write(input logic [10:0] a, input logic [15:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk(arr_wr && arr_waddr == a && arr_wdata == v, "R6 write drive", {arr_wr, 4'h0, arr_waddr, arr_wdata}, {1'b1, 4'h0, a, v});
    begin
      bit saw_rsp = 1'b0;
      int guard = 0;
      while (!req_ready && guard < 50) begin
        if (rsp_valid) saw_rsp = 1'b1;
        @(negedge clk);
        guard++;
      end
      chk(!saw_rsp, "R6 no response", 32'(saw_rsp), 0);
    end
    ref_mem[a] = v;
  endtask

  // {we, addr[10:0], wdata[15:0], expect_hit}
  localparam int NV = 13;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 11'h000, 16'h0000, 1'b0},
    {1'b0, 11'h005, 16'h0000, 1'b1},
    {1'b0, 11'h007, 16'h0000, 1'b1},
    {1'b0, 11'h008, 16'h0000, 1'b0},
    {1'b0, 11'h00F, 16'h0000, 1'b1},
    {1'b0, 11'h003, 16'h0000, 1'b0},
    {1'b1, 11'h002, 16'hBEEF, 1'b0},
    {1'b0, 11'h002, 16'h0000, 1'b1},
    {1'b1, 11'h409, 16'h1111, 1'b0},
    {1'b0, 11'h001, 16'h0000, 1'b1},
    {1'b0, 11'h409, 16'h0000, 1'b0},
    {1'b0, 11'h7FF, 16'h0000, 1'b0},
    {1'b0, 11'h7F8, 16'h0000, 1'b1}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    logic [15:0] d;
    bit act_seen, row_ok;
    int lat;
    for (int i = 0; i < 2048; i++) begin
      arr_mem[i] = seed_val(i);
      ref_mem[i] = seed_val(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!rsp_valid && req_ready && !row_act && !arr_wr, "R1 idle outputs",
        {rsp_valid, req_ready, row_act, arr_wr}, 4'b0100);
    chk(cnt_full == 0 && cnt_ler == 0, "R1 counters", {cnt_full, cnt_ler}, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [28:0] v;
      v = VEC[k];
      if (v[28]) begin
        do_write(v[27:17], v[16:1]);
      end else begin
        do_read(v[27:17], d, act_seen, lat, row_ok);
        chk(d == ref_mem[v[27:17]], v[0] ? "R4 hit word" : "R2 fill word", d, ref_mem[v[27:17]]);
        chk(act_seen == !v[0], k == 0 ? "R1 first read misses" : (v[0] ? "R3 no activation" : "R2 activation"),
            32'(act_seen), 32'(!v[0]));
        if (v[0]) chk(lat == 1, "R3 hit latency", lat, 1);
        else chk(row_ok, "R2 row address", 32'(row_ok), 1);
        if (k == 7) chk(d == 16'hBEEF, "R7 patched word", d, 16'hBEEF);
        if (k == 9) chk(d == seed_val(1), "R7 other row untouched", d, seed_val(1));
      end
    end
    chk(cnt_full == 8'd5, "R9 full count", cnt_full, 5);
    chk(cnt_ler == 8'd6, "R9 ler count", cnt_ler, 6);

    // R5 seven hits after one full read
    do_read(11'h100, d, act_seen, lat, row_ok);
    chk(act_seen && d == ref_mem[11'h100], "R5 opening full read", d, ref_mem[11'h100]);
    for (int w = 1; w < 8; w++) begin
      do_read(11'h100 + 11'(w), d, act_seen, lat, row_ok);
      chk(!act_seen && lat == 1 && d == ref_mem[11'h100 + 11'(w)], "R5 row word hit",
          {act_seen, 15'(lat), d}, {1'b0, 15'd1, ref_mem[11'h100 + 11'(w)]});
    end

    // R8 response back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 11'h105;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
    for (int s = 0; s < 3; s++) begin
      chk(rsp_valid && !req_ready && rsp_data == ref_mem[11'h105], "R8 held under stall",
          {rsp_valid, req_ready, rsp_data}, {1'b1, 1'b0, ref_mem[11'h105]});
      @(negedge clk);
    end
    chk(rsp_data == d && rsp_valid, "R8 data stable", rsp_data, d);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8 release", {rsp_valid, req_ready}, 2'b01);

    // R10 fill word from incoming row, tag replaced
    do_read(11'h103, d, act_seen, lat, row_ok);
    chk(!act_seen, "R10 pre hit", 32'(act_seen), 0);
    do_read(11'h003, d, act_seen, lat, row_ok);
    chk(act_seen && d == ref_mem[11'h003] && d != ref_mem[11'h103], "R10 fill from new row",
        d, ref_mem[11'h003]);
    do_read(11'h103, d, act_seen, lat, row_ok);
    chk(act_seen && d == ref_mem[11'h103], "R10 old row now misses", 32'(act_seen), 1);

    // R9 saturation
    begin
      logic [7:0] full_before;
      full_before = cnt_full;
      for (int n = 0; n < 260; n++) begin
        do_read(11'h104, d, act_seen, lat, row_ok);
      end
      chk(cnt_ler == 8'hFF, "R9 ler saturates", cnt_ler, 8'hFF);
      chk(cnt_full == full_before, "R9 full unchanged by hits", cnt_full, full_before);
    end

    finish_run();
  end
endmodule